// File: doc/BRIEF.md
# Reset and Start-up Time-out Sequencer

This block decides when a microcontroller core may leave reset and, once it does, what the core should know about why it stopped. It watches a power-good level, an active-low master-clear pin, a watchdog expiry pulse, a watchdog-clear pulse, a sleep request from the core and an interrupt wake request. For each reset or wake event it picks a time-out: a power-up delay counted in reference-clock ticks, an oscillator settling delay counted in oscillator cycles, the longer of both, or none at all. The core is held until that time-out has run.

The oscillator settling delay applies only when a crystal or resonator drives the core clock (low-frequency or standard crystal mode), and only after power-on, a wake from sleep, or a master-clear while asleep. Oscillator cycles are counted only while an amplitude-valid qualifier is high. On release, the block presents two cause flags, a resume selector (reset vector or the instruction after the sleep) and an interrupt-mask flag. Oscillator and reference cycles arrive as single-cycle strobes in the system clock domain. The power-good level also serves as the block's asynchronous reset.

The controller has four states. HOLD waits for master clear to go high. TIMING runs both counters. RUN lets the core execute. SLEEP covers the period while the core is asleep. Its transitions are: HOLD to TIMING when master clear is high; TIMING to HOLD when master clear is low; TIMING to RUN when the required timers are met; RUN to HOLD on master clear low; RUN to TIMING on watchdog expiry; RUN to SLEEP on a sleep request; SLEEP to HOLD on master clear low; SLEEP to TIMING on watchdog expiry or interrupt wake. In RUN and in SLEEP, master clear takes priority over the watchdog, and the watchdog takes priority over any other request.

Top module: `rst_seq`

## Requirements
- R1: While `por_ok` is low, `core_hold`=1, `flag_nwdt`=1, `flag_nslp`=1, `resume_next`=0 and `irq_mask_flag`=1. After `por_ok` rises, the block waits in HOLD until `mclr_n` is high.
- R2: After power-on in a crystal mode (`osc_mode` 2'b00 low-frequency or 2'b01 standard crystal), `core_hold` falls only when two conditions are both met: PWR_TICKS `ref_tick` strobes have been counted, and OSC_CYCLES qualified `osc_tick` strobes have been counted. Counting starts in the cycle after `mclr_n` is first seen high. `core_hold` falls one cycle after the later of the two limits is reached.
- R3: After power-on in an external-clock mode (`osc_mode` 2'b10 or 2'b11), only the power-up count governs release. Oscillator strobes have no effect on it.
- R4: An `osc_tick` strobe counts only while `osc_amp_ok` is high. Strobes seen while it is low lengthen the time-out.
- R5: `mclr_n` low while running holds the core for as long as it stays low. `core_hold` falls two cycles after `mclr_n` is seen high, with no timer, and the flags read nwdt=1, nslp=1 with `resume_next`=0.
- R6: `mclr_n` low during sleep gives flags nwdt=1, nslp=0 and `resume_next`=0. After `mclr_n` rises, the oscillator count applies in crystal modes.
- R7: A `wdt_timeout` pulse while running holds the core for exactly one cycle and gives flags nwdt=0, nslp=1 with `resume_next`=0.
- R8: A `wdt_timeout` pulse during sleep gives flags nwdt=0, nslp=0 and `resume_next`=0. The oscillator count applies in crystal modes.
- R9: An `int_wake` during sleep gives flags nwdt=1, nslp=0 and `resume_next`=1. It copies `glob_int_off` into `irq_mask_flag`. The oscillator count applies in crystal modes, and the wake is released after one cycle in external-clock modes.
- R10: A `wdt_clear` pulse while running sets both flags to 1 without holding the core.
- R11: Every reset event (power-on, master clear or watchdog) sets `irq_mask_flag` to 1.
- R12: `mclr_n` going low during a time-out restarts both counts. Release after `mclr_n` rises again needs the full sequence for the pending event.
- R13: In RUN and in SLEEP, master clear wins over a simultaneous watchdog expiry, and watchdog expiry wins over the other requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_ok | input | 1 | Power-good level; low acts as asynchronous reset |
| mclr_n | input | 1 | Active-low master clear |
| wdt_timeout | input | 1 | Watchdog expiry pulse |
| wdt_clear | input | 1 | Watchdog-clear pulse from the core |
| sleep_req | input | 1 | Core enters sleep |
| int_wake | input | 1 | Interrupt wake request |
| glob_int_off | input | 1 | Current global interrupt-disable bit |
| osc_mode | input | 2 | 00 LF crystal, 01 XT crystal, 10 external clock, 11 RC |
| osc_tick | input | 1 | One strobe per oscillator cycle |
| osc_amp_ok | input | 1 | Oscillator amplitude valid qualifier |
| ref_tick | input | 1 | One strobe per power-up timer reference period |
| core_hold | output | 1 | Core held in reset or time-out |
| flag_nwdt | output | 1 | 0 after a watchdog reset |
| flag_nslp | output | 1 | 0 after an event taken during sleep |
| resume_next | output | 1 | 1: continue at next instruction; 0: reset vector |
| irq_mask_flag | output | 1 | Interrupt-mask status presented after release |

## Verification
Several properties are checked on every cycle. Master clear low always forces the hold. Release never comes before the counters the pending event requires. A counter never steps without a qualified strobe and clears when idle. A watchdog pulse while running, a watchdog-clear pulse and an interrupt wake each produce their flags one cycle later. The exact release cycle for each mix of oscillator mode and strobe rate can only be shown by the bench's cycle-accurate model. The same holds for the restart after master clear drops mid-count, the longer-timer-wins cases in both directions, and the contents of the interrupt-mask flag across chained events.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_TIMING = 2'd1,
        ST_RUN    = 2'd2,
        ST_SLEEP  = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        CAUSE_POWER    = 3'd0,
        CAUSE_MCLR_RUN = 3'd1,
        CAUSE_MCLR_SLP = 3'd2,
        CAUSE_WDT_RUN  = 3'd3,
        CAUSE_WDT_SLP  = 3'd4,
        CAUSE_INT_WAKE = 3'd5,
        CAUSE_WDT_CLR  = 3'd6
    } cause_e;

    localparam logic [1:0] OSC_LF  = 2'b00;
    localparam logic [1:0] OSC_XT  = 2'b01;
    localparam logic [1:0] OSC_EXT = 2'b10;
    localparam logic [1:0] OSC_RC  = 2'b11;

endpackage

// File: rtl/rst_tick_counter.sv
module rst_tick_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic qual,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable) begin
            cnt <= '0;
        end else if (tick && qual && !done) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R12: an idle counter is empty on the next cycle
    a_r12_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0));

    // R4: a step needs a qualified strobe in the previous cycle
    a_r4_step_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt) && cnt != '0) |-> $past(tick && qual && enable));

    // R2: once reached, the limit is held while enabled
    a_r2_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable) |=> done);

endmodule

// File: rtl/rst_cause_map.sv
module rst_cause_map
    import rst_seq_pkg::*;
(
    input  cause_e cause,
    output logic   nwdt,
    output logic   nslp,
    output logic   resume,
    output logic   need_pwr,
    output logic   need_osc
);
    always_comb begin
        nwdt     = 1'b1;
        nslp     = 1'b1;
        resume   = 1'b0;
        need_pwr = 1'b0;
        need_osc = 1'b0;
        unique case (cause)
            CAUSE_POWER: begin
                need_pwr = 1'b1;
                need_osc = 1'b1;
            end
            CAUSE_MCLR_RUN, CAUSE_WDT_CLR: begin
            end
            CAUSE_MCLR_SLP: begin
                nslp     = 1'b0;
                need_osc = 1'b1;
            end
            CAUSE_WDT_RUN: begin
                nwdt = 1'b0;
            end
            CAUSE_WDT_SLP: begin
                nwdt     = 1'b0;
                nslp     = 1'b0;
                need_osc = 1'b1;
            end
            CAUSE_INT_WAKE: begin
                nslp     = 1'b0;
                resume   = 1'b1;
                need_osc = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rst_seq.sv
module rst_seq
    import rst_seq_pkg::*;
#(
    parameter int OSC_CYCLES = 1024,
    parameter int PWR_TICKS  = 96
) (
    input  logic       clk,
    input  logic       por_ok,
    input  logic       mclr_n,
    input  logic       wdt_timeout,
    input  logic       wdt_clear,
    input  logic       sleep_req,
    input  logic       int_wake,
    input  logic       glob_int_off,
    input  logic [1:0] osc_mode,
    input  logic       osc_tick,
    input  logic       osc_amp_ok,
    input  logic       ref_tick,
    output logic       core_hold,
    output logic       flag_nwdt,
    output logic       flag_nslp,
    output logic       resume_next,
    output logic       irq_mask_flag
);
    seq_state_e state_q, state_d;
    cause_e     cause_q, cause_d;
    logic       irqm_q, irqm_d;

    logic enc_nwdt, enc_nslp, enc_resume, enc_need_pwr, enc_need_osc;
    logic crystal, need_osc, timing_en, osc_done, pwr_done, timers_met;

    rst_cause_map u_map (
        .cause    (cause_q),
        .nwdt     (enc_nwdt),
        .nslp     (enc_nslp),
        .resume   (enc_resume),
        .need_pwr (enc_need_pwr),
        .need_osc (enc_need_osc)
    );

    assign crystal   = (osc_mode == OSC_LF) || (osc_mode == OSC_XT);
    assign need_osc  = enc_need_osc && crystal;
    assign timing_en = (state_q == ST_TIMING);

    rst_tick_counter #(.LIMIT(OSC_CYCLES)) u_osc_settle (
        .clk    (clk),
        .rst_n  (por_ok),
        .enable (timing_en),
        .tick   (osc_tick),
        .qual   (osc_amp_ok),
        .done   (osc_done)
    );

    rst_tick_counter #(.LIMIT(PWR_TICKS)) u_pwr_delay (
        .clk    (clk),
        .rst_n  (por_ok),
        .enable (timing_en),
        .tick   (ref_tick),
        .qual   (1'b1),
        .done   (pwr_done)
    );

    assign timers_met = (!enc_need_pwr || pwr_done) && (!need_osc || osc_done);

    // next-state and cause selection
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        irqm_d  = irqm_q;
        unique case (state_q)
            ST_HOLD: begin
                if (mclr_n) state_d = ST_TIMING;
            end
            ST_TIMING: begin
                if (!mclr_n)         state_d = ST_HOLD;
                else if (timers_met) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!mclr_n) begin
                    state_d = ST_HOLD;
                    cause_d = CAUSE_MCLR_RUN;
                    irqm_d  = 1'b1;
                end else if (wdt_timeout) begin
                    state_d = ST_TIMING;
                    cause_d = CAUSE_WDT_RUN;
                    irqm_d  = 1'b1;
                end else if (wdt_clear) begin
                    cause_d = CAUSE_WDT_CLR;
                end else if (sleep_req) begin
                    state_d = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!mclr_n) begin
                    state_d = ST_HOLD;
                    cause_d = CAUSE_MCLR_SLP;
                    irqm_d  = 1'b1;
                end else if (wdt_timeout) begin
                    state_d = ST_TIMING;
                    cause_d = CAUSE_WDT_SLP;
                    irqm_d  = 1'b1;
                end else if (int_wake) begin
                    state_d = ST_TIMING;
                    cause_d = CAUSE_INT_WAKE;
                    irqm_d  = glob_int_off;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_ok) begin
        if (!por_ok) begin
            state_q <= ST_HOLD;
            cause_q <= CAUSE_POWER;
            irqm_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            irqm_q  <= irqm_d;
        end
    end

    // outputs
    always_comb begin
        core_hold     = (state_q == ST_HOLD) || (state_q == ST_TIMING);
        flag_nwdt     = enc_nwdt;
        flag_nslp     = enc_nslp;
        resume_next   = enc_resume;
        irq_mask_flag = irqm_q;
    end

    // R5/R6/R12: master clear low always leads to hold
    a_r5_hold_on_mclr: assert property (@(posedge clk) disable iff (!por_ok)
        !mclr_n |=> core_hold);

    // R2/R3: release only after the required counters finished
    a_r2_release_after_timers: assert property (@(posedge clk) disable iff (!por_ok)
        $fell(core_hold) |-> $past((!enc_need_pwr || pwr_done) && (!need_osc || osc_done)));

    // R7: watchdog expiry while running
    a_r7_wdt_run: assert property (@(posedge clk) disable iff (!por_ok)
        (state_q == ST_RUN && mclr_n && wdt_timeout)
            |=> (core_hold && !flag_nwdt && flag_nslp && !resume_next));

    // R10: watchdog clear keeps the core running
    a_r10_clear_runs: assert property (@(posedge clk) disable iff (!por_ok)
        (state_q == ST_RUN && mclr_n && !wdt_timeout && wdt_clear)
            |=> (!core_hold && flag_nwdt && flag_nslp));

    // R9: interrupt wake resumes and copies the mask bit
    a_r9_int_wake: assert property (@(posedge clk) disable iff (!por_ok)
        (state_q == ST_SLEEP && mclr_n && !wdt_timeout && int_wake)
            |=> (resume_next && !flag_nslp && irq_mask_flag == $past(glob_int_off)));

endmodule

// File: tb/tb_rst_seq.sv
`timescale 1ns/1ps
module tb_rst_seq;
    localparam int OSC_N = 32;
    localparam int PWR_N = 20;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       por_ok = 1'b0, mclr_n = 1'b0, wdt_timeout = 1'b0, wdt_clear = 1'b0;
    logic       sleep_req = 1'b0, int_wake = 1'b0, glob_int_off = 1'b0;
    logic [1:0] osc_mode = 2'b01;
    logic       osc_tick = 1'b0, osc_amp_ok = 1'b1, ref_tick = 1'b0;
    logic       core_hold, flag_nwdt, flag_nslp, resume_next, irq_mask_flag;

    rst_seq #(.OSC_CYCLES(OSC_N), .PWR_TICKS(PWR_N)) dut (
        .clk(clk), .por_ok(por_ok), .mclr_n(mclr_n), .wdt_timeout(wdt_timeout),
        .wdt_clear(wdt_clear), .sleep_req(sleep_req), .int_wake(int_wake),
        .glob_int_off(glob_int_off), .osc_mode(osc_mode), .osc_tick(osc_tick),
        .osc_amp_ok(osc_amp_ok), .ref_tick(ref_tick), .core_hold(core_hold),
        .flag_nwdt(flag_nwdt), .flag_nslp(flag_nslp), .resume_next(resume_next),
        .irq_mask_flag(irq_mask_flag)
    );

    // behavioural reference: phase 0 wait-for-pin, 1 counting, 2 running, 3 asleep
    int phase = 0, osc_left = OSC_N, pwr_left = PWR_N;
    bit m_nwdt = 1, m_nslp = 1, m_res = 0, m_mask = 1, want_pwr = 1, want_osc = 1;

    always @(posedge clk) begin
        if (!por_ok) begin
            phase = 0; m_nwdt = 1; m_nslp = 1; m_res = 0; m_mask = 1;
            want_pwr = 1; want_osc = 1; osc_left = OSC_N; pwr_left = PWR_N;
        end else begin
            if (phase != 1) begin osc_left = OSC_N; pwr_left = PWR_N; end
            case (phase)
                0: if (mclr_n) phase = 1;
                1: begin
                    if (!mclr_n) phase = 0;
                    else if ((!want_pwr || pwr_left == 0) &&
                             (!(want_osc && !osc_mode[1]) || osc_left == 0)) phase = 2;
                    else begin
                        if (osc_tick && osc_amp_ok && osc_left > 0) osc_left--;
                        if (ref_tick && pwr_left > 0) pwr_left--;
                    end
                end
                2: begin
                    if (!mclr_n) begin
                        phase = 0; m_nwdt = 1; m_nslp = 1; m_res = 0; m_mask = 1;
                        want_pwr = 0; want_osc = 0;
                    end else if (wdt_timeout) begin
                        phase = 1; m_nwdt = 0; m_nslp = 1; m_res = 0; m_mask = 1;
                        want_pwr = 0; want_osc = 0;
                    end else if (wdt_clear) begin
                        m_nwdt = 1; m_nslp = 1; m_res = 0; want_pwr = 0; want_osc = 0;
                    end else if (sleep_req) phase = 3;
                end
                default: begin
                    if (!mclr_n) begin
                        phase = 0; m_nwdt = 1; m_nslp = 0; m_res = 0; m_mask = 1;
                        want_pwr = 0; want_osc = 1;
                    end else if (wdt_timeout) begin
                        phase = 1; m_nwdt = 0; m_nslp = 0; m_res = 0; m_mask = 1;
                        want_pwr = 0; want_osc = 1;
                    end else if (int_wake) begin
                        phase = 1; m_nwdt = 1; m_nslp = 0; m_res = 1; m_mask = glob_int_off;
                        want_pwr = 0; want_osc = 1;
                    end
                end
            endcase
        end
    end

    int n_cmp = 0, n_bad = 0, cyc_n = 0, osc_div = 1, ref_div = 2;
    string req = "R1";

    task automatic check(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc_n, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check("core_hold", core_hold, (phase == 0 || phase == 1));
        check("flag_nwdt", flag_nwdt, m_nwdt);
        check("flag_nslp", flag_nslp, m_nslp);
        check("resume_next", resume_next, m_res);
        check("irq_mask_flag", irq_mask_flag, m_mask);
        cyc_n++;
        osc_tick = (cyc_n % osc_div) == 0;
        ref_tick = (cyc_n % ref_div) == 0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic power_on(logic [1:0] mode);
        osc_mode = mode; por_ok = 1'b0; mclr_n = 1'b1; step(); step(); por_ok = 1'b1;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; step(); sig = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog all-requirements: actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        req = "R1"; run(4);                          // R1 reset state, pin low
        por_ok = 1'b1; run(5);                       // R1 waits in HOLD while mclr_n low
        req = "R2"; mclr_n = 1'b1; run(60);          // R2 XT, power-up timer longer
        req = "R2"; osc_div = 4; power_on(2'b00); run(150); // R2 LF, oscillator longer
        req = "R3"; osc_div = 6; power_on(2'b10); run(60);  // R3 external clock ignores osc
        req = "R4"; osc_div = 1; osc_amp_ok = 1'b0; power_on(2'b01); run(50);
        osc_amp_ok = 1'b1; run(50);                  // R4 unqualified strobes ignored
        req = "R12"; power_on(2'b11); run(12); mclr_n = 1'b0; run(3); mclr_n = 1'b1; run(60);
        req = "R12"; osc_div = 2; ref_div = 1; power_on(2'b01); run(20);
        mclr_n = 1'b0; run(2); mclr_n = 1'b1; run(90);
        ref_div = 2; osc_div = 1;
        req = "R5"; mclr_n = 1'b0; run(4); mclr_n = 1'b1; run(6);
        req = "R10"; pulse(wdt_clear); run(3);
        req = "R7"; pulse(wdt_timeout); run(4);
        req = "R10"; pulse(wdt_clear); run(2);
        req = "R9"; glob_int_off = 1'b0; pulse(sleep_req); run(3); pulse(int_wake); run(45);
        req = "R11"; pulse(wdt_timeout); run(4);    // R11 mask back to 1
        req = "R9"; glob_int_off = 1'b1; pulse(sleep_req); pulse(int_wake); run(45);
        req = "R9"; osc_mode = 2'b11; glob_int_off = 1'b0; pulse(sleep_req); run(2);
        pulse(int_wake); run(4);
        req = "R8"; osc_mode = 2'b00; pulse(sleep_req); run(2); pulse(wdt_timeout); run(45);
        req = "R8"; osc_mode = 2'b10; pulse(sleep_req); pulse(wdt_timeout); run(4);
        req = "R6"; osc_mode = 2'b01; pulse(sleep_req); run(2);
        mclr_n = 1'b0; run(3); mclr_n = 1'b1; run(45);
        req = "R13"; mclr_n = 1'b0; wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
        mclr_n = 1'b1; run(4);
        req = "R13"; pulse(sleep_req); wdt_timeout = 1'b1; int_wake = 1'b1; step();
        wdt_timeout = 1'b0; int_wake = 1'b0; run(45);
        req = "R13"; pulse(sleep_req); mclr_n = 1'b0; wdt_timeout = 1'b1; step();
        wdt_timeout = 1'b0; mclr_n = 1'b1; run(45);
        req = "R1"; por_ok = 1'b0; run(3);          // R1 power loss mid-run
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule